// File: doc/BRIEF.md
# NAND Flash Bus Controller

This block sits as a slave on a simple 32-bit register bus and drives an 8-bit raw NAND flash. Software sets the command-latch, address-latch and chip-enable levels directly through a mode register. Each access to the data register then turns into one timed flash strobe. A write sends the low byte of the bus word on a write strobe, and a read returns the byte sampled from the flash on a read strobe.

The strobe width and the data hold time come from a timing register and are counted in bus clocks. A data access waits through a ready signal until its strobe has finished. A second data access that arrives during the hold window waits until that window ends. A status register shows when the flash or the controller is busy. A self-clearing soft-reset bit puts the mode and timing registers back to their defaults.

Register word offsets used by the requirements: data 0x00, mode 0x04, status 0x08, timing 0x14, soft reset 0x18. Every other offset reads as zero and ignores writes.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After `rst_n` is released, all four `nand_ce_n` lines are high, `nand_cle`, `nand_ale` and `nand_doe` are low, both strobes are high, and the mode register reads 0.
- R2: Mode bit 0 drives `nand_cle` and mode bit 1 drives `nand_ale` from the next clock after the write.
- R3: When mode bit 4 is 1, exactly the line `nand_ce_n[k]` is low, where k is mode bits 3:2. When bit 4 is 0, all four lines are high.
- R4: With mode bit 7 set, a write to the data register gives one `nand_we_n` low pulse of SPW+1 clocks. SPW is timing bits 3:0. The pulse carries `bus_wdata[7:0]` on `nand_dout`, with `nand_doe` high.
- R5: With mode bit 7 clear, a write to the data register completes at once and produces no strobe and no output enable.
- R6: A read of the data register gives one `nand_re_n` low pulse of SPW+1 clocks. Its bits 7:0 return the value of `nand_din` present during the last strobe clock. The read is held off for SPW+2 clocks.
- R7: After a write strobe, `nand_doe` and `nand_dout` stay driven for HOLD+2 clocks, where HOLD is timing bits 7:4. A data access issued in that window is stalled through `bus_ready`, and its strobe starts HOLD+3 clocks after the previous strobe ended.
- R8: An SPW or HOLD field of 0 behaves as 1.
- R9: Status bit 7 reads 1 while `nand_rdy` is low or while a strobe or hold sequence is running, and 0 otherwise.
- R10: Writing 1 to soft-reset bit 0 makes that bit read 1 for exactly 4 clocks. It then reads 0, and the mode and timing registers read 0 again.
- R11: Accesses to registers other than data complete in the cycle they are presented. The timing register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when `bus_ready` is high |
| bus_ready | output | 1 | Access completes at the clock edge while high |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 4 | Active-low chip enables |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dout | output | 8 | Byte driven toward the flash |
| nand_doe | output | 1 | Output enable for `nand_dout` |
| nand_din | input | 8 | Byte from the flash |
| nand_rdy | input | 1 | Flash ready (1) / busy (0) |

## Verification
The hardest state to reach from the ports is a data access that arrives during the hold window of the previous write. The bench issues a second data write right after the first one completes, and then measures the stall and the exact number of high clocks between the two write pulses. Controller busy is reached the same way. The bench reads status in the clock right after a write completes, while the hold phase is still running. The soft-reset countdown is checked with back-to-back reads of the reset register, so that the clock in which the bit clears is pinned exactly.

// File: rtl/nbc_pkg.sv
// Package: shared types, register word indices and mode bit positions
// for the NAND bus controller. Assumes byte addressing with word-aligned registers.
package nbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_DONE   = 2'd2,
        ST_HOLD   = 2'd3
    } nbc_state_e;

    localparam int REG_DATA  = 0;
    localparam int REG_MODE  = 1;
    localparam int REG_STAT  = 2;
    localparam int REG_TIME  = 5;
    localparam int REG_SRST  = 6;

    localparam int MB_CLE    = 0;
    localparam int MB_ALE    = 1;
    localparam int MB_CSLO   = 2;
    localparam int MB_CEON   = 4;
    localparam int MB_WGATE  = 7;
    localparam int SB_BUSY   = 7;
endpackage

// File: rtl/nbc_regs.sv
// Register file: decodes the bus, holds mode and timing, runs the
// self-clearing soft reset and builds read data for the non-data registers.
// Assumes the bus holds its request stable until completion.
module nbc_regs
    import nbc_pkg::*;
#(
    parameter int AW         = 5,
    parameter int RST_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    input  logic          busy_any,
    output logic          is_data,
    output logic [7:0]    mode_q,
    output logic [7:0]    time_q,
    output logic [31:0]   reg_rdata
);
    localparam int IW = AW - 2;
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    logic [IW-1:0] widx;
    logic          srst_q;
    logic [CW-1:0] srst_cnt;
    logic          wr_en;
    logic [23:0]   unused_hi;
    logic [1:0]    unused_lo;

    assign widx      = bus_addr[AW-1:2];
    assign is_data   = (widx == IW'(REG_DATA));
    assign wr_en     = bus_sel & bus_wr;
    assign unused_hi = bus_wdata[31:8];
    assign unused_lo = bus_addr[1:0];

    // Register writes and soft-reset countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            time_q   <= '0;
            srst_q   <= 1'b0;
            srst_cnt <= '0;
        end else if (srst_q) begin
            if (srst_cnt == '0) begin
                srst_q <= 1'b0;
                mode_q <= '0;
                time_q <= '0;
            end else begin
                srst_cnt <= srst_cnt - 1'b1;
            end
        end else if (wr_en) begin
            if (widx == IW'(REG_MODE)) mode_q <= bus_wdata[7:0];
            if (widx == IW'(REG_TIME)) time_q <= bus_wdata[7:0];
            if (widx == IW'(REG_SRST) && bus_wdata[0]) begin
                srst_q   <= 1'b1;
                srst_cnt <= CW'(RST_CYCLES - 1);
            end
        end
    end

    // Read multiplexer for the non-data registers.
    always_comb begin
        reg_rdata = '0;
        case (widx)
            IW'(REG_MODE): reg_rdata[7:0] = mode_q;
            IW'(REG_STAT): reg_rdata[SB_BUSY] = busy_any;
            IW'(REG_TIME): reg_rdata[7:0] = time_q;
            IW'(REG_SRST): reg_rdata[0] = srst_q;
            default:       reg_rdata = '0;
        endcase
    end

    // R10: once raised, the reset bit stays set for the next clock.
    p_srst_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srst_q) |=> srst_q);
endmodule

// File: rtl/nbc_strobe.sv
// Strobe engine: for each accepted data access it produces one timed
// read or write strobe, a one-clock completion slot, and a hold window.
// Assumes start is only honoured in the idle state.
module nbc_strobe
    import nbc_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_wr,
    input  logic [DW-1:0] wbyte,
    input  logic [TW-1:0] spw,
    input  logic [TW-1:0] hold,
    input  logic [DW-1:0] nand_din,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rbyte,
    output logic          we_n,
    output logic          re_n,
    output logic [DW-1:0] dout,
    output logic          doe
);
    nbc_state_e    st;
    logic [TW-1:0] cnt;
    logic          is_wr;
    logic [TW-1:0] spw_eff;
    logic [TW-1:0] hold_eff;
    logic          stb_act;

    assign spw_eff  = (spw  == '0) ? TW'(1) : spw;
    assign hold_eff = (hold == '0) ? TW'(1) : hold;
    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_DONE);
    assign stb_act  = (st == ST_STROBE);
    assign we_n     = !(stb_act && is_wr);
    assign re_n     = !(stb_act && !is_wr);
    assign doe      = is_wr && (st != ST_IDLE);

    // Phase sequencing: strobe, completion slot, hold, back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            is_wr <= 1'b0;
            dout  <= '0;
            rbyte <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st    <= ST_STROBE;
                    cnt   <= spw_eff;
                    is_wr <= start_wr;
                    if (start_wr) dout <= wbyte;
                end
                ST_STROBE: if (cnt == '0) begin
                    st <= ST_DONE;
                    if (!is_wr) rbyte <= nand_din;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_DONE: begin
                    st  <= ST_HOLD;
                    cnt <= hold_eff;
                end
                default: if (cnt == '0) begin
                    st    <= ST_IDLE;
                    is_wr <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    // R4: read and write strobes never overlap.
    p_strobe_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we_n || re_n);
    // R7: driven byte is stable while output enable stays on.
    p_dout_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (doe && $past(doe)) |-> $stable(dout));
    // R7: no strobe during the hold window.
    p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> (we_n && re_n));
    // R8: a strobe is never shorter than two clocks.
    p_strobe_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_act) |=> stb_act);
endmodule

// File: rtl/nbc_pins.sv
// Pin driver: turns mode bits into latch-enable levels and a one-cold
// chip-enable vector. Assumes NUM_CS is a power of two.
module nbc_pins
    import nbc_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        mode_q,
    output logic              cle,
    output logic              ale,
    output logic [NUM_CS-1:0] ce_n
);
    localparam int SW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic [SW-1:0] csel;

    assign cle  = mode_q[MB_CLE];
    assign ale  = mode_q[MB_ALE];
    assign csel = mode_q[MB_CSLO +: SW];

    // One active-low enable per chip select.
    for (genvar k = 0; k < NUM_CS; k++) begin : g_ce
        assign ce_n[k] = !(mode_q[MB_CEON] && (csel == SW'(k)));
    end

    // R3: at most one chip enable is active.
    p_ce_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));
endmodule

// File: rtl/nand_bus_ctrl.sv
// Top: bus slave that drives an 8-bit NAND flash. Data accesses launch
// a timed strobe and stall the bus until their strobe completes;
// other registers answer at once. Assumes one outstanding bus access.
module nand_bus_ctrl
    import nbc_pkg::*;
#(
    parameter int AW     = 5,
    parameter int NUM_CS = 4,
    parameter int DW     = 8,
    parameter int TW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic [NUM_CS-1:0] nand_ce_n,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DW-1:0]     nand_dout,
    output logic              nand_doe,
    input  logic [DW-1:0]     nand_din,
    input  logic              nand_rdy
);
    logic          is_data;
    logic [7:0]    mode_q;
    logic [7:0]    time_q;
    logic [31:0]   reg_rdata;
    logic          eng_busy;
    logic          eng_done;
    logic [DW-1:0] rbyte;
    logic          data_go;

    assign data_go   = bus_sel && is_data && (!bus_wr || mode_q[MB_WGATE]);
    assign bus_ready = !data_go || eng_done;
    assign bus_rdata = is_data ? 32'(rbyte) : reg_rdata;

    nbc_regs #(.AW(AW), .RST_CYCLES(4)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .busy_any(eng_busy || !nand_rdy),
        .is_data(is_data), .mode_q(mode_q), .time_q(time_q),
        .reg_rdata(reg_rdata)
    );

    nbc_strobe #(.DW(DW), .TW(TW)) u_strobe (
        .clk(clk), .rst_n(rst_n),
        .start(data_go && !eng_busy), .start_wr(bus_wr),
        .wbyte(bus_wdata[DW-1:0]),
        .spw(time_q[TW-1:0]), .hold(time_q[2*TW-1:TW]),
        .nand_din(nand_din),
        .busy(eng_busy), .done(eng_done), .rbyte(rbyte),
        .we_n(nand_we_n), .re_n(nand_re_n),
        .dout(nand_dout), .doe(nand_doe)
    );

    nbc_pins #(.NUM_CS(NUM_CS)) u_pins (
        .clk(clk), .rst_n(rst_n), .mode_q(mode_q),
        .cle(nand_cle), .ale(nand_ale), .ce_n(nand_ce_n)
    );

    // R11: ready only drops for a gated data access.
    p_ready_nondata_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !is_data) |-> bus_ready);
endmodule

// File: tb/test_nand_bus_ctrl.sv
module test_nand_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_doe;
    logic [3:0]  nand_ce_n;
    logic [7:0]  nand_dout;
    logic [7:0]  nand_din = 8'h00;
    logic        nand_rdy = 1'b1;

    int checks = 0;
    int errors = 0;

    // pulse / gap / hold monitors, sampled at the falling edge
    int wlen = 0, w_last = 0, w_pulses = 0, w_gap = 0, gap_last = 0;
    int rlen = 0, r_last = 0, r_pulses = 0;
    int hcnt = 0, h_last = 0, doe_seen = 0;
    logic [7:0] dout_at_pulse = '0;

    always #10 clk = ~clk;

    nand_bus_ctrl i_nand_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dout(nand_dout), .nand_doe(nand_doe), .nand_din(nand_din),
        .nand_rdy(nand_rdy)
    );

    always @(negedge clk) begin
        if (nand_doe) doe_seen++;
        if (!nand_we_n) begin
            if (wlen == 0) begin gap_last = w_gap; dout_at_pulse = nand_dout; end
            wlen++;
        end else begin
            if (wlen > 0) begin w_last = wlen; w_pulses++; wlen = 0; w_gap = 0; end
            w_gap++;
        end
        if (!nand_re_n) rlen++;
        else if (rlen > 0) begin r_last = rlen; r_pulses++; rlen = 0; end
        if (nand_doe && nand_we_n) hcnt++;
        else if (!nand_doe && hcnt > 0) begin h_last = hcnt; hcnt = 0; end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [4:0] a, input logic w, input logic [31:0] d,
                        output logic [31:0] q, output int waits);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        waits = 0;
        #1;
        while (!bus_ready) begin
            @(negedge clk); #1; waits++;
        end
        q = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        logic [31:0] q; int wt;
        xfer(a, 1'b1, d, q, wt);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] q);
        int wt;
        xfer(a, 1'b0, 32'h0, q, wt);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [31:0] q;
        check("R1 ce_n", 32'(nand_ce_n), 32'hF);
        check("R1 cle/ale", {30'd0, nand_cle, nand_ale}, 32'h0);
        check("R1 strobes", {29'd0, nand_we_n, nand_re_n, nand_doe}, 32'h6);
        rd(5'h04, q);
        check("R1 mode reads 0", q, 32'h0);
    endtask

    task automatic t_latches();
        wr(5'h04, 32'h03);
        check("R2 cle+ale", {30'd0, nand_cle, nand_ale}, 32'h3);
        wr(5'h04, 32'h02);
        check("R2 ale only", {30'd0, nand_cle, nand_ale}, 32'h1);
        wr(5'h04, 32'h01);
        check("R2 cle only", {30'd0, nand_cle, nand_ale}, 32'h2);
    endtask

    task automatic t_chip_enable();
        for (int k = 0; k < 4; k++) begin
            wr(5'h04, 32'h10 | (k << 2));
            check("R3 ce select", 32'(nand_ce_n), 32'(~(4'b1 << k) & 4'hF));
        end
        wr(5'h04, 32'h0C);
        check("R3 ce off", 32'(nand_ce_n), 32'hF);
    endtask

    task automatic t_timing_rb();
        logic [31:0] q; int wt;
        xfer(5'h14, 1'b1, 32'h5A, q, wt);
        check("R11 write no stall", 32'(wt), 32'h0);
        xfer(5'h14, 1'b0, 32'h0, q, wt);
        check("R11 timing readback", q, 32'h5A);
        check("R11 read no stall", 32'(wt), 32'h0);
    endtask

    task automatic t_write_gated_off();
        logic [31:0] q; int wt; int p0, d0;
        wr(5'h04, 32'h10);
        p0 = w_pulses; d0 = doe_seen;
        xfer(5'h00, 1'b1, 32'hC3, q, wt);
        idle(6);
        check("R5 no stall", 32'(wt), 32'h0);
        check("R5 no pulse", 32'(w_pulses - p0), 32'h0);
        check("R5 no doe", 32'(doe_seen - d0), 32'h0);
    endtask

    task automatic t_write_strobe();
        logic [31:0] q; int p0;
        wr(5'h04, 32'h90);
        wr(5'h14, 32'h23);          // HOLD=2 SPW=3
        p0 = w_pulses;
        xfer(5'h00, 1'b1, 32'h1234_56A7, q, p0);
        p0 = w_pulses;
        idle(8);
        check("R4 pulse width", 32'(w_last), 32'd4);
        check("R4 dout byte", 32'(dout_at_pulse), 32'hA7);
        check("R7 hold length", 32'(h_last), 32'd4);
    endtask

    task automatic t_busy_and_stall();
        logic [31:0] q; int wt;
        wr(5'h14, 32'h52);          // HOLD=5 SPW=2
        wr(5'h00, 32'h11);
        rd(5'h08, q);
        check("R9 busy in hold", q, 32'h80);
        idle(10);
        rd(5'h08, q);
        check("R9 idle not busy", q, 32'h0);
        nand_rdy = 1'b0;
        rd(5'h08, q);
        check("R9 flash busy", q, 32'h80);
        nand_rdy = 1'b1;
        wr(5'h00, 32'h22);
        xfer(5'h00, 1'b1, 32'h33, q, wt);
        idle(10);
        check("R7 stalled", 32'(wt > 0), 32'h1);
        check("R7 gap", 32'(gap_last), 32'd8);
        check("R7 hold 5", 32'(h_last), 32'd7);
    endtask

    task automatic t_zero_fields();
        wr(5'h14, 32'h00);
        wr(5'h00, 32'h44);
        idle(6);
        check("R8 spw0 width", 32'(w_last), 32'd2);
        check("R8 hold0 length", 32'(h_last), 32'd3);
    endtask

    task automatic t_read();
        logic [31:0] q; int wt; int p0;
        wr(5'h14, 32'h12);          // HOLD=1 SPW=2
        nand_din = 8'h5C;
        p0 = r_pulses;
        xfer(5'h00, 1'b0, 32'h0, q, wt);
        idle(5);
        check("R6 read data", q, 32'h5C);
        check("R6 read stall", 32'(wt), 32'd4);
        check("R6 re width", 32'(r_last), 32'd3);
        check("R6 one pulse", 32'(r_pulses - p0), 32'd1);
    endtask

    task automatic t_soft_reset();
        logic [31:0] q;
        wr(5'h04, 32'h9C);
        wr(5'h14, 32'h35);
        wr(5'h18, 32'h1);
        for (int i = 0; i < 4; i++) begin
            rd(5'h18, q);
            check("R10 bit held", q, 32'h1);
        end
        rd(5'h18, q);
        check("R10 bit cleared", q, 32'h0);
        rd(5'h04, q);
        check("R10 mode default", q, 32'h0);
        rd(5'h14, q);
        check("R10 timing default", q, 32'h0);
        check("R10 ce released", 32'(nand_ce_n), 32'hF);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_latches();
        t_chip_enable();
        t_timing_rb();
        t_write_gated_off();
        t_write_strobe();
        t_busy_and_stall();
        t_zero_fields();
        t_read();
        t_soft_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule